// File: doc/BRIEF.md
# Binary-Integer Negacyclic Polynomial Multiply-Accumulate

This block computes `F·D + H` in the ring of polynomials with `N` coefficients, reduced modulo `x^N + 1`. Each coefficient is also reduced modulo `2^W`. `F` and `H` carry `W`-bit integer coefficients. `D` carries one-bit coefficients. Because every term of `D` is 0 or 1, each partial product is either a rotated copy of `F` or nothing. The datapath therefore holds only conditional adders and no coefficient multipliers.

Two identical lanes run side by side, and each lane rotates its operand by `x^2` per cycle:

- The even lane starts from `F` with its accumulator preset to `H`. It consumes the even-indexed terms of `D`.
- The odd lane starts from `F·x` with its accumulator cleared. It consumes the odd-indexed terms of `D`.

After `N/2` processing cycles, the two accumulators are summed coefficient by coefficient to form the result.

An operation begins when `start_i` is sampled high while the block is idle. The operands are captured on that edge. The result appears in parallel on `result_o`, marked by a one-cycle `done_o` pulse, and stays there until the next accepted start.

Top module: `bnm_mac`

## Requirements
- R1: `result_o` equals `F·D + H` reduced modulo `x^N + 1`, with every coefficient taken modulo `2^W`.
- R2: A term whose degree reaches `N` or more re-enters at degree `k - N` with its sign inverted (two's complement within `W` bits). For example, `F = 5·x^(N-1)` with `D = x` gives coefficient 0 equal to `2^W - 5`, and every other coefficient equal to zero.
- R3: When every bit of `d_i` is zero, the result equals `H` exactly.
- R4: When every bit of `d_i` is one, the result equals `H` plus the sum of `F·x^j` for `j` from 0 to `N-1`, each term taken with negacyclic wrap.
- R5: `done_o` is high for exactly one cycle. That cycle begins `N/2 + 1` rising edges after the edge that accepted the start, counting the accepting edge as the first.
- R6: After `done_o`, `result_o` holds its value until another start is accepted.
- R7: While busy, `start_i` is ignored and any change on `f_i`, `d_i` or `h_i` is ignored. The result and the timing of `done_o` both follow the operands captured at the accepted start.
- R8: After reset, `busy_o` and `done_o` are low and `result_o` is zero. `busy_o` is high from the edge that accepts a start until the edge that raises `done_o`, where it falls.
- R9: The data buses use these fixed positions:
  - Coefficient `i` of `F`, `H` and the result occupies bits `[i*W +: W]` of its bus.
  - Bit `i` of `d_i` is the coefficient of `x^i` in `D`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin; accepted only when idle |
| f_i | input | N*W | Integer operand F, coefficient i at bits [i*W +: W] |
| d_i | input | N | Binary operand D, bit i is the coefficient of x^i |
| h_i | input | N*W | Integer addend H, same packing as f_i |
| busy_o | output | 1 | High while the lanes are processing |
| done_o | output | 1 | One-cycle pulse when result_o becomes valid |
| result_o | output | N*W | Result coefficients, same packing as f_i |

## Verification
The hardest condition to create from the ports is a start request, or a change of operand, that arrives during a run. If the block obeyed it, the run would be cut short or the result corrupted.

To create it, the bench keeps `start_i` high for almost the whole run and puts fresh random values on all three operand buses on every processing cycle. It then requires `done_o` at the cycle predicted from the first accepted start, and a result computed from the captured operands only.

The wrap path is driven separately, using a single top-degree coefficient of `F` together with a lone odd-indexed bit of `D`. That combination sends the only product term through the odd lane's pre-shift and its negated re-entry.

// File: rtl/bnm_pkg.sv
package bnm_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } bnm_state_e;
endpackage

// File: rtl/bnm_rot.sv
// Negacyclic rotation by x^STEP: coefficients move up STEP places, those
// pushed past degree N-1 re-enter at the bottom negated modulo 2^W.
module bnm_rot #(
   parameter int N    = 256,
   parameter int W    = 8,
   parameter int STEP = 2
) (
   input  logic [N*W-1:0] a_i,
   output logic [N*W-1:0] y_o
);
   localparam logic [W-1:0] ZERO = '0;

   initial begin
      assert (STEP >= 1 && STEP < N) else $error("bnm_rot: STEP out of range");
   end

   for (genvar i = 0; i < N; i++) begin : g_coef
      if (i >= STEP) begin : g_move
         assign y_o[i*W +: W] = a_i[(i-STEP)*W +: W];
      end else begin : g_wrap
         assign y_o[i*W +: W] = ZERO - a_i[(N-STEP+i)*W +: W];
      end
   end
endmodule

// File: rtl/bnm_lane.sv
// One x^2-stepping shift structure with its own accumulator.
module bnm_lane #(
   parameter int N = 256,
   parameter int W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  logic           step_i,
   input  logic           dbit_i,
   input  logic [N*W-1:0] opnd_init_i,
   input  logic [N*W-1:0] acc_init_i,
   output logic [N*W-1:0] acc_o
);
   logic [N*W-1:0] opnd_q;
   logic [N*W-1:0] acc_q;
   logic [N*W-1:0] opnd_next;
   logic [N*W-1:0] acc_sum;

   bnm_rot #(.N(N), .W(W), .STEP(2)) u_rot2 (
      .a_i (opnd_q),
      .y_o (opnd_next)
   );

   for (genvar i = 0; i < N; i++) begin : g_add
      assign acc_sum[i*W +: W] = acc_q[i*W +: W] + opnd_q[i*W +: W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opnd_q <= '0;
         acc_q  <= '0;
      end else if (load_i) begin
         opnd_q <= opnd_init_i;
         acc_q  <= acc_init_i;
      end else if (step_i) begin
         opnd_q <= opnd_next;
         if (dbit_i) acc_q <= acc_sum;
      end
   end

   assign acc_o = acc_q;

   // R6
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !(step_i && dbit_i)) |=> $stable(acc_q));

   // R7
   opnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !step_i) |=> $stable(opnd_q));
endmodule

// File: rtl/bnm_ctrl.sv
// Sequencer: accepts a start when idle, runs N/2 step cycles, pulses done.
module bnm_ctrl #(
   parameter int N = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic busy_o,
   output logic done_o
);
   import bnm_pkg::*;

   localparam int HALF = N / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);
   localparam logic [CW-1:0] ONE  = CW'(1);

   bnm_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_RUN;
                  cnt_q   <= '0;
               end
            end
            ST_RUN: begin
               cnt_q <= cnt_q + ONE;
               if (cnt_q == LAST) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign load_o = (state_q == ST_IDLE) && start_i;
   assign step_o = (state_q == ST_RUN);
   assign busy_o = (state_q == ST_RUN);
   assign done_o = done_q;

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($past(busy_o) && !busy_o));

   // R7
   busy_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cnt_q != LAST) |=> (busy_o && !done_o));
endmodule

// File: rtl/bnm_mac.sv
// Binary-integer negacyclic multiply-accumulate, two x^2 lanes in parallel.
module bnm_mac #(
   parameter int N = 256,
   parameter int W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [N*W-1:0] f_i,
   input  logic [N-1:0]   d_i,
   input  logic [N*W-1:0] h_i,
   output logic           busy_o,
   output logic           done_o,
   output logic [N*W-1:0] result_o
);
   localparam int LANES = 2;

   initial begin
      assert (N >= 2 && (N % 2) == 0) else $error("bnm_mac: N must be even and >= 2");
      assert (W >= 1) else $error("bnm_mac: W must be positive");
   end

   logic           load;
   logic           step;
   logic [N-1:0]   dsh_q;
   logic [N*W-1:0] f_x1;
   logic [N*W-1:0] acc [LANES];

   bnm_ctrl #(.N(N)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .load_o  (load),
      .step_o  (step),
      .busy_o  (busy_o),
      .done_o  (done_o)
   );

   // D bits consumed two per cycle: bit 0 feeds the even lane, bit 1 the odd.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dsh_q <= '0;
      else if (load) dsh_q <= d_i;
      else if (step) dsh_q <= dsh_q >> 2;
   end

   bnm_rot #(.N(N), .W(W), .STEP(1)) u_pre (
      .a_i (f_i),
      .y_o (f_x1)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (l == 0) begin : g_even
         bnm_lane #(.N(N), .W(W)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (load),
            .step_i      (step),
            .dbit_i      (dsh_q[0]),
            .opnd_init_i (f_i),
            .acc_init_i  (h_i),
            .acc_o       (acc[l])
         );
      end else begin : g_odd
         bnm_lane #(.N(N), .W(W)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (load),
            .step_i      (step),
            .dbit_i      (dsh_q[1]),
            .opnd_init_i (f_x1),
            .acc_init_i  ('0),
            .acc_o       (acc[l])
         );
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_sum
      assign result_o[i*W +: W] = acc[0][i*W +: W] + acc[1][i*W +: W];
   end

   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(result_o));
endmodule

// File: tb/bnm_mac_tb.sv
module bnm_mac_tb;
   localparam int N    = 32;
   localparam int W    = 8;
   localparam int HALF = N / 2;
   localparam int MASK = (1 << W) - 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start_i = 1'b0;
   logic [N*W-1:0] f_i = '0;
   logic [N-1:0]   d_i = '0;
   logic [N*W-1:0] h_i = '0;
   logic           busy_o;
   logic           done_o;
   logic [N*W-1:0] result_o;

   int nchk = 0;
   int nfail = 0;
   int fa [N];
   int ha [N];
   bit da [N];
   int exp_r [N];

   always #2.5 clk = ~clk;

   bnm_mac #(.N(N), .W(W)) u_dut (
      .clk (clk), .rst_n (rst_n), .start_i (start_i),
      .f_i (f_i), .d_i (d_i), .h_i (h_i),
      .busy_o (busy_o), .done_o (done_o), .result_o (result_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic pack_ops();
      for (int i = 0; i < N; i++) begin
         f_i[i*W +: W] = W'(fa[i]);
         h_i[i*W +: W] = W'(ha[i]);
         d_i[i]        = da[i];
      end
   endtask

   // Behavioural schoolbook negacyclic product plus addend.
   task automatic model();
      for (int i = 0; i < N; i++) exp_r[i] = ha[i];
      for (int j = 0; j < N; j++) begin
         if (da[j]) begin
            for (int i = 0; i < N; i++) begin
               if (i + j < N) exp_r[i+j]   = exp_r[i+j] + fa[i];
               else           exp_r[i+j-N] = exp_r[i+j-N] - fa[i];
            end
         end
      end
      for (int i = 0; i < N; i++) exp_r[i] = exp_r[i] & MASK;
   endtask

   task automatic check_result(input string req);
      int bad = 0;
      int bi = 0;
      for (int i = 0; i < N; i++) begin
         if (int'(result_o[i*W +: W]) != exp_r[i]) begin
            if (bad == 0) bi = i;
            bad++;
         end
      end
      check(bad == 0, req, $sformatf("result coefficient %0d", bi),
            result_o[bi*W +: W], exp_r[bi]);
   endtask

   // Runs one operation, comparing busy/done on every cycle against the model.
   task automatic run_op(input string req, input bit noisy);
      model();
      @(negedge clk);
      pack_ops();
      start_i = 1'b1;
      @(posedge clk);
      for (int k = 0; k <= HALF; k++) begin
         @(negedge clk);
         check(busy_o == (k < HALF), "R8", $sformatf("busy at cycle %0d", k), busy_o, k < HALF);
         check(done_o == (k == HALF), "R5", $sformatf("done at cycle %0d", k), done_o, k == HALF);
         if (k == HALF) begin
            check_result(req);
         end else begin
            // R7: keep start high and churn operands while busy
            if (noisy && k < HALF - 1) begin
               start_i = 1'b1;
               for (int i = 0; i < N; i++) begin
                  f_i[i*W +: W] = W'($urandom);
                  h_i[i*W +: W] = W'($urandom);
                  d_i[i]        = 1'($urandom);
               end
            end else begin
               start_i = 1'b0;
            end
            @(posedge clk);
         end
      end
      start_i = 1'b0;
   endtask

   task automatic rand_ops(input int dmode);
      for (int i = 0; i < N; i++) begin
         fa[i] = int'($urandom) & MASK;
         ha[i] = int'($urandom) & MASK;
         da[i] = (dmode == 0) ? 1'b0 : (dmode == 1) ? 1'b1 : 1'($urandom);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8: reset state
      check(busy_o == 1'b0, "R8", "busy after reset", busy_o, 0);
      check(done_o == 1'b0, "R8", "done after reset", done_o, 0);
      check(result_o == '0, "R8", "result after reset", result_o[W-1:0], 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy_o == 1'b0 && done_o == 1'b0, "R8", "idle after release", busy_o, 0);

      // R3: zero D returns H
      rand_ops(0);
      run_op("R3", 1'b0);

      // R4: all-ones D
      rand_ops(1);
      run_op("R4", 1'b0);

      // R9: D = 1 (bit 0) returns F + H in place
      rand_ops(0);
      da[0] = 1'b1;
      run_op("R9", 1'b0);

      // R2: top coefficient times x wraps to degree 0 negated
      for (int i = 0; i < N; i++) begin fa[i] = 0; ha[i] = 0; da[i] = 1'b0; end
      fa[N-1] = 5;
      da[1] = 1'b1;
      run_op("R2", 1'b0);
      check(int'(result_o[W-1:0]) == ((1 << W) - 5), "R2", "wrapped coefficient 0",
            result_o[W-1:0], (1 << W) - 5);

      // R2: even-lane wrap through x^2 steps
      for (int i = 0; i < N; i++) begin fa[i] = 0; ha[i] = 0; da[i] = 1'b0; end
      fa[N-2] = 7;
      fa[3] = 9;
      da[4] = 1'b1;
      run_op("R2", 1'b0);

      // R1: random operands
      for (int t = 0; t < 6; t++) begin
         rand_ops(2);
         run_op("R1", 1'b0);
      end

      // R6: result holds while idle with inputs changing but no start
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         f_i = {N{W'($urandom)}};
         d_i = N'($urandom);
         check(done_o == 1'b0, "R5", "done stays low when idle", done_o, 0);
         check_result("R6");
      end

      // R7: start and operand churn during the run are ignored
      for (int t = 0; t < 2; t++) begin
         rand_ops(2);
         run_op("R7", 1'b1);
      end

      // R1: back-to-back start accepted in the done cycle
      rand_ops(2);
      model();
      pack_ops();
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 1'b1, "R8", "busy after back-to-back start", busy_o, 1);
      repeat (HALF) @(posedge clk);
      @(negedge clk);
      check(done_o == 1'b1, "R5", "done after back-to-back run", done_o, 1);
      check_result("R1");

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule